// File: doc/BRIEF.md
# Conditional Data-Processing ALU

This block carries out one data-processing operation on two operands, but only if a 4-bit condition code holds against the incoming N, Z, C and V flags. The caller supplies an opcode, a condition, a set-flags bit, a first operand, a second operand, the carry-out of an upstream shifter, and the current flags. The block returns a write-enable for the destination, the result, and the flag values that the caller should hold next. Operand shifting, register-file access and status restore are done elsewhere in the datapath.

Operations enter on a valid/ready stream and leave on one. The output is registered, so each accepted operation appears one clock later. Back-pressure works as follows. `in_ready` is high whenever the output register is empty, or will be emptied on the same edge because `out_ready` is high. While `out_valid` is high and `out_ready` is low, every output is held and no new operation is accepted. Flags are bundled as `{N,Z,C,V}` on bits 3..0 of both flag buses.

Top module: `cond_alu`

## Requirements
- R1: The condition passes against `in_flags` = {N,Z,C,V} as follows:
  - 0000 when Z=1; 0001 when Z=0.
  - 0010 when C=1; 0011 when C=0.
  - 0100 when N=1; 0101 when N=0.
  - 0110 when V=1; 0111 when V=0.
  - 1000 when C=1 and Z=0; 1001 when C=0 or Z=1.
  - 1010 when N=V; 1011 when N!=V.
  - 1100 when Z=0 and N=V; 1101 when Z=1 or N!=V.
  - 1110 always; 1111 never.
- R2: When the condition fails, the block returns `out_we`=0, `out_res`=0 and `out_flags` equal to the incoming flags.
- R3: The opcodes are:
  - 0000 a AND b; 0001 a XOR b; 1100 a OR b; 1110 a AND NOT b.
  - 1101 b; 1111 NOT b.
  - 0100 a+b; 0101 a+b+C.
  - 0010 a-b; 0110 a-b-NOT C.
  - 0011 b-a; 0111 b-a-NOT C.
  - The result is taken modulo 2^W.
- R4: The add forms (0100, 0101, 1011) set C to the carry out of the top bit and V to signed overflow.
- R5: The subtract forms (0010, 0011, 0110, 0111, 1010) set C to NOT borrow, that is C=1 when no borrow occurs, and set V to signed overflow of the subtraction.
- R6: The logical and move forms set C to `in_shc` and leave V unchanged.
- R7: With `in_setf`=1 and a passing condition, N is the top result bit and Z=1 exactly when the result is zero. With `in_setf`=0, a non-compare operation returns the incoming flags unchanged.
- R8: The compare forms 1000 (as AND), 1001 (as XOR), 1010 (as a-b) and 1011 (as a+b) update the flags whatever `in_setf` is, return their computed result on `out_res`, and never assert `out_we`. Every other opcode asserts `out_we` when its condition passes.
- R9: An operation accepted on a clock edge appears on the outputs with `out_valid`=1 after that edge. While `out_valid`=1 and `out_ready`=0, all outputs hold and `in_ready`=0.
- R10: After reset `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted |
| in_op | input | 4 | Opcode |
| in_cond | input | 4 | Condition code |
| in_setf | input | 1 | Set-flags request |
| in_a | input | W | First operand |
| in_b | input | W | Second operand |
| in_shc | input | 1 | Shifter carry-out |
| in_flags | input | 4 | Current {N,Z,C,V} |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| out_we | output | 1 | Destination write-enable |
| out_res | output | W | Result |
| out_flags | output | 4 | Next {N,Z,C,V} |

## Verification
Every result is due on the edge after the one that accepted its operation. It then stays on the outputs for as long as `out_ready` is held low. The bench drives inputs and `out_ready` on falling edges and samples just after them. It pushes the expected item into a queue when an operation is accepted, and pops and compares it only on a cycle where the output handshake completes. Random stalls therefore shift when each result is compared without breaking the order of the results.

// File: rtl/calu_pkg.sv
package calu_pkg;
  localparam int FLAG_W = 4;
  localparam int FN = 3;
  localparam int FZ = 2;
  localparam int FC = 1;
  localparam int FV = 0;

  typedef enum logic [3:0] {
    OP_AND = 4'b0000, OP_EOR = 4'b0001, OP_SUB = 4'b0010, OP_RSB = 4'b0011,
    OP_ADD = 4'b0100, OP_ADC = 4'b0101, OP_SBC = 4'b0110, OP_RSC = 4'b0111,
    OP_TST = 4'b1000, OP_TEQ = 4'b1001, OP_CMP = 4'b1010, OP_CMN = 4'b1011,
    OP_ORR = 4'b1100, OP_MOV = 4'b1101, OP_BIC = 4'b1110, OP_MVN = 4'b1111
  } alu_op_e;

  function automatic logic is_compare(input logic [3:0] op);
    return op[3:2] == 2'b10;
  endfunction
endpackage

// File: rtl/calu_cond.sv
module calu_cond
  import calu_pkg::*;
(
  input  logic [3:0]        cond,
  input  logic [FLAG_W-1:0] flags,
  output logic              pass
);
  logic n, z, c, v, base;
  assign n = flags[FN];
  assign z = flags[FZ];
  assign c = flags[FC];
  assign v = flags[FV];

  // Even codes test a predicate; odd codes below 1110 test its inverse.
  always_comb begin
    unique case (cond[3:1])
      3'd0: base = z;
      3'd1: base = c;
      3'd2: base = n;
      3'd3: base = v;
      3'd4: base = c & ~z;
      3'd5: base = (n == v);
      3'd6: base = ~z & (n == v);
      default: base = 1'b1;
    endcase
    if (cond[3:1] == 3'd7) pass = ~cond[0];
    else                   pass = base ^ cond[0];
  end
endmodule

// File: rtl/calu_exec.sv
module calu_exec
  import calu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]        op,
  input  logic              setf,
  input  logic [W-1:0]      a,
  input  logic [W-1:0]      b,
  input  logic              shc,
  input  logic [FLAG_W-1:0] flags,
  output logic [W-1:0]      res,
  output logic [FLAG_W-1:0] nflags,
  output logic              we_op
);
  localparam int MSB = W - 1;

  logic [W-1:0] x, y, logic_res;
  logic         cin, arith, upd;
  logic [W:0]   sum;
  logic         ovf;

  // Operand steering for the single shared adder: subtraction is x + ~y + cin.
  always_comb begin
    x = a; y = b; cin = 1'b0; arith = 1'b1;
    unique case (op)
      OP_ADD, OP_CMN: begin x = a; y = b;  cin = 1'b0;        end
      OP_ADC:         begin x = a; y = b;  cin = flags[FC];   end
      OP_SUB, OP_CMP: begin x = a; y = ~b; cin = 1'b1;        end
      OP_SBC:         begin x = a; y = ~b; cin = flags[FC];   end
      OP_RSB:         begin x = b; y = ~a; cin = 1'b1;        end
      OP_RSC:         begin x = b; y = ~a; cin = flags[FC];   end
      default:        arith = 1'b0;
    endcase
  end

  assign sum = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
  assign ovf = (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);

  always_comb begin
    unique case (op)
      OP_AND, OP_TST: logic_res = a & b;
      OP_EOR, OP_TEQ: logic_res = a ^ b;
      OP_ORR:         logic_res = a | b;
      OP_BIC:         logic_res = a & ~b;
      OP_MOV:         logic_res = b;
      OP_MVN:         logic_res = ~b;
      default:        logic_res = '0;
    endcase
  end

  assign res   = arith ? sum[W-1:0] : logic_res;
  assign we_op = ~is_compare(op);
  assign upd   = setf | is_compare(op);

  always_comb begin
    nflags = flags;
    if (upd) begin
      nflags[FN] = res[MSB];
      nflags[FZ] = (res == '0);
      nflags[FC] = arith ? sum[W] : shc;
      nflags[FV] = arith ? ovf : flags[FV];
    end
  end
endmodule

// File: rtl/calu_oreg.sv
module calu_oreg
  import calu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              drain,
  input  logic              d_we,
  input  logic [W-1:0]      d_res,
  input  logic [FLAG_W-1:0] d_flags,
  output logic              q_valid,
  output logic              q_we,
  output logic [W-1:0]      q_res,
  output logic [FLAG_W-1:0] q_flags
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_we    <= 1'b0;
      q_res   <= '0;
      q_flags <= '0;
    end else if (load) begin
      q_valid <= 1'b1;
      q_we    <= d_we;
      q_res   <= d_res;
      q_flags <= d_flags;
    end else if (drain) begin
      q_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/cond_alu.sv
module cond_alu
  import calu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        in_op,
  input  logic [3:0]        in_cond,
  input  logic              in_setf,
  input  logic [W-1:0]      in_a,
  input  logic [W-1:0]      in_b,
  input  logic              in_shc,
  input  logic [FLAG_W-1:0] in_flags,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_we,
  output logic [W-1:0]      out_res,
  output logic [FLAG_W-1:0] out_flags
);
  logic              pass, we_op;
  logic [W-1:0]      ex_res;
  logic [FLAG_W-1:0] ex_flags;
  logic              d_we;
  logic [W-1:0]      d_res;
  logic [FLAG_W-1:0] d_flags;

  calu_cond u_cond (.cond(in_cond), .flags(in_flags), .pass(pass));

  calu_exec #(.W(W)) u_exec (
    .op(in_op), .setf(in_setf), .a(in_a), .b(in_b), .shc(in_shc),
    .flags(in_flags), .res(ex_res), .nflags(ex_flags), .we_op(we_op)
  );

  assign d_we    = pass & we_op;
  assign d_res   = pass ? ex_res : '0;
  assign d_flags = pass ? ex_flags : in_flags;

  assign in_ready = ~out_valid | out_ready;

  calu_oreg #(.W(W)) u_oreg (
    .clk(clk), .rst_n(rst_n),
    .load(in_valid & in_ready), .drain(out_ready),
    .d_we(d_we), .d_res(d_res), .d_flags(d_flags),
    .q_valid(out_valid), .q_we(out_we), .q_res(out_res), .q_flags(out_flags)
  );
endmodule

// File: rtl/calu_chk.sv
module calu_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [3:0]   in_op,
  input logic [3:0]   in_cond,
  input logic         in_setf,
  input logic [3:0]   in_flags,
  input logic         out_valid,
  input logic         out_ready,
  input logic         out_we,
  input logic [W-1:0] out_res,
  input logic [3:0]   out_flags
);
  logic [3:0] c_op, c_cond, c_flags;
  logic       c_setf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_op <= '0; c_cond <= '0; c_flags <= '0; c_setf <= 1'b0;
    end else if (in_valid && in_ready) begin
      c_op <= in_op; c_cond <= in_cond; c_flags <= in_flags; c_setf <= in_setf;
    end
  end

  logic c_logic;
  assign c_logic = (c_op[3:1] == 3'b000) || (c_op[3:1] == 3'b100) || (c_op[3:2] == 2'b11);

  // R10
  reset_empty_chk: assert property (@(posedge clk) $rose(rst_n) |-> !out_valid);
  // R9
  accept_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_res) && $stable(out_we) && $stable(out_flags));
  // R1
  always_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && c_cond == 4'hE && c_op[3:2] != 2'b10 |-> out_we);
  // R2
  never_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && c_cond == 4'hF |-> !out_we && out_flags == c_flags && out_res == '0);
  // R8
  compare_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && c_op[3:2] == 2'b10 |-> !out_we);
  // R7
  noset_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !c_setf && c_op[3:2] != 2'b10 |-> out_flags == c_flags);
  // R6
  logic_keeps_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && c_logic |-> out_flags[0] == c_flags[0]);
endmodule

bind cond_alu calu_chk #(.W(W)) u_calu_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_cond(in_cond), .in_setf(in_setf), .in_flags(in_flags),
  .out_valid(out_valid), .out_ready(out_ready), .out_we(out_we),
  .out_res(out_res), .out_flags(out_flags)
);

// File: tb/cond_alu_test.sv
module cond_alu_test;
  localparam int W = 32;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, in_setf = 1'b0, in_shc = 1'b0;
  logic [3:0] in_op = '0, in_cond = '0, in_flags = '0;
  logic [W-1:0] in_a = '0, in_b = '0;
  logic out_valid, out_ready = 1'b1, out_we;
  logic [W-1:0] out_res;
  logic [3:0] out_flags;

  always #4 clk = ~clk;

  cond_alu #(.W(W)) uut (.*);

  typedef struct packed {
    logic       we;
    logic [W-1:0] res;
    logic [3:0] fl;
    logic [7:0] tag;
  } exp_t;

  exp_t sb[$];
  int n_vec = 0, n_bad = 0;
  bit done = 0;
  bit stall_mode = 0;

  function automatic bit ref_pass(input logic [3:0] cd, input logic [3:0] f);
    bit n = f[3], z = f[2], c = f[1], v = f[0];
    case (cd)
      4'h0: return z;           4'h1: return !z;
      4'h2: return c;           4'h3: return !c;
      4'h4: return n;           4'h5: return !n;
      4'h6: return v;           4'h7: return !v;
      4'h8: return c && !z;     4'h9: return !c || z;
      4'hA: return n == v;      4'hB: return n != v;
      4'hC: return !z && n == v; 4'hD: return z || n != v;
      4'hE: return 1;           default: return 0;
    endcase
  endfunction

  function automatic exp_t ref_model(input logic [3:0] op, cd, input logic s,
                                     input logic [W-1:0] a, b, input logic sh,
                                     input logic [3:0] f, input logic [7:0] tag);
    exp_t e;
    longint sa = longint'($signed(a)), sb_ = longint'($signed(b)), sr;
    logic [W+1:0] wide;
    bit arith = 1, cmp = (op >= 4'h8 && op <= 4'hB);
    logic nc = !f[1];
    logic [W-1:0] r;
    logic cf, vf;
    e.tag = tag;
    sr = 0; wide = '0; r = '0;
    case (op)
      4'h4, 4'hB: begin wide = a + b;             sr = sa + sb_; end
      4'h5:       begin wide = a + b + f[1];      sr = sa + sb_ + f[1]; end
      4'h2, 4'hA: begin wide = {2'b0,a} - b;      sr = sa - sb_; end
      4'h6:       begin wide = {2'b0,a} - b - nc; sr = sa - sb_ - nc; end
      4'h3:       begin wide = {2'b0,b} - a;      sr = sb_ - sa; end
      4'h7:       begin wide = {2'b0,b} - a - nc; sr = sb_ - sa - nc; end
      default: arith = 0;
    endcase
    case (op)
      4'h0, 4'h8: r = a & b;
      4'h1, 4'h9: r = a ^ b;
      4'hC: r = a | b;
      4'hE: r = a & ~b;
      4'hD: r = b;
      4'hF: r = ~b;
      default: r = wide[W-1:0];
    endcase
    if (arith) begin
      if (op inside {4'h4, 4'h5, 4'hB}) cf = wide[W];
      else cf = !wide[W+1];
      vf = (sr > longint'(32'sh7FFFFFFF)) || (sr < -longint'(64'h80000000));
    end else begin
      cf = sh; vf = f[0];
    end
    if (!ref_pass(cd, f)) begin
      e.we = 0; e.res = '0; e.fl = f;
    end else begin
      e.we = !cmp; e.res = r;
      e.fl = (s || cmp) ? {r[W-1], r == '0, cf, vf} : f;
    end
    return e;
  endfunction

  task automatic send(input logic [3:0] op, cd, input logic s,
                      input logic [W-1:0] a, b, input logic sh,
                      input logic [3:0] f, input logic [7:0] tag);
    @(negedge clk);
    in_op = op; in_cond = cd; in_setf = s; in_a = a; in_b = b;
    in_shc = sh; in_flags = f; in_valid = 1'b1;
    #2;
    while (!in_ready) begin @(negedge clk); #2; end
    sb.push_back(ref_model(op, cd, s, a, b, sh, f, tag));
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  // Monitor: sets out_ready at each falling edge, then compares if a handshake is pending.
  initial begin
    forever begin
      @(negedge clk);
      out_ready = stall_mode ? ($urandom_range(0, 2) != 0) : 1'b1;
      #1;
      if (rst_n && out_valid && out_ready) begin
        exp_t e;
        n_vec++;
        if (sb.size() == 0) begin
          n_bad++;
          $display("FAIL R9: result with empty scoreboard actual res=%h expected none", out_res);
        end else begin
          e = sb.pop_front();
          if (out_we !== e.we || out_res !== e.res || out_flags !== e.fl) begin
            n_bad++;
            $display("FAIL R%0d: we/res/flags actual %b/%h/%b expected %b/%h/%b",
                     e.tag, out_we, out_res, out_flags, e.we, e.res, e.fl);
          end
        end
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R10: output register empty after reset
    n_vec++;
    if (out_valid !== 1'b0) begin
      n_bad++; $display("FAIL R10: out_valid actual %b expected 0", out_valid);
    end
    @(negedge clk) rst_n = 1'b1;

    // R1 / R2: every condition code against several flag sets
    for (int cd = 0; cd < 16; cd++)
      for (int f = 0; f < 16; f += 5)
        send(4'hD, cd[3:0], 1'b1, 32'h0, 32'h1234, 1'b1, f[3:0], (ref_pass(cd[3:0], f[3:0]) ? 8'd1 : 8'd2));

    // R3 every opcode, R7 S=0 leaves flags
    for (int op = 0; op < 16; op++) begin
      send(op[3:0], 4'hE, 1'b1, 32'hF0F0_1234, 32'h0FF0_4321, 1'b0, 4'b0010, 8'd3);
      send(op[3:0], 4'hE, 1'b0, 32'h8000_0001, 32'h7FFF_FFFF, 1'b1, 4'b1011, 8'd7);
    end

    // R4: carry and overflow edges of add
    send(4'h4, 4'hE, 1'b1, 32'h7FFF_FFFF, 32'h1, 1'b0, 4'b0000, 8'd4);
    send(4'h4, 4'hE, 1'b1, 32'hFFFF_FFFF, 32'h1, 1'b0, 4'b0000, 8'd4);
    send(4'h5, 4'hE, 1'b1, 32'hFFFF_FFFE, 32'h1, 1'b0, 4'b0010, 8'd4);
    // R5: borrow and NOT-C forms of subtract
    send(4'h2, 4'hE, 1'b1, 32'h0, 32'h1, 1'b0, 4'b0000, 8'd5);
    send(4'h2, 4'hE, 1'b1, 32'h5, 32'h5, 1'b0, 4'b0000, 8'd5);
    send(4'h6, 4'hE, 1'b1, 32'h5, 32'h5, 1'b0, 4'b0000, 8'd5);
    send(4'h7, 4'hE, 1'b1, 32'h0, 32'h0, 1'b0, 4'b0000, 8'd5);
    send(4'h3, 4'hE, 1'b1, 32'h1, 32'h8000_0000, 1'b0, 4'b0000, 8'd5);
    // R6: logical C from shifter, V kept
    send(4'h0, 4'hE, 1'b1, 32'h0, 32'hFFFF, 1'b1, 4'b0001, 8'd6);
    send(4'hF, 4'hE, 1'b1, 32'h0, 32'hFFFF_FFFF, 1'b0, 4'b0011, 8'd6);
    // R8: compares update flags even with S=0, never write
    send(4'hA, 4'hE, 1'b0, 32'h3, 32'h3, 1'b0, 4'b0000, 8'd8);
    send(4'hB, 4'hE, 1'b0, 32'hFFFF_FFFF, 32'h1, 1'b0, 4'b0000, 8'd8);

    // R9: random traffic under random back-pressure
    stall_mode = 1;
    for (int i = 0; i < 600; i++) begin
      logic [3:0] cd;
      cd = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'hE;
      send(4'($urandom), cd, 1'($urandom), $urandom, $urandom, 1'($urandom), 4'($urandom), 8'd9);
    end
    stall_mode = 0;
    repeat (10) @(posedge clk);
    #1;
    n_vec++;
    if (sb.size() != 0) begin
      n_bad++; $display("FAIL R9: pending results actual %0d expected 0", sb.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule